// File: doc/BRIEF.md
# Serial-Wire to JTAG Mode Switch Detector

This block sits on the shared debug clock and the shared data/TMS line of a two-protocol debug port. It samples the line on every rising clock edge and decides which protocol engine owns the port. To move the port into JTAG mode, a debugger first holds the line high for a long run of clocks. That run puts both engines into their idle state. The debugger then sends a fixed 16-bit select word, least-significant bit first, with no gap after the run. When the last bit of the word is sampled, the mode output goes to JTAG and a one-cycle pulse is raised.

The block also watches for runs of ones while JTAG mode is active. Once enough consecutive ones have arrived, either after the select word or after any 0, it raises a flag that tells the TAP state machine it is in Test-Logic-Reset. A debugger that is unsure of the port state can therefore send run, word and trailing ones, and end up in a known TAP state whatever mode the port was in before. A parameter selects the mode taken at reset. By default the port wakes in JTAG mode and needs no setup. The serial-wire engine and the TAP state machine are outside this block.

Top module: `swj_mode_detect`

## Requirements
- R1: While reset is asserted and right after it is released, `jtag_mode_o` equals the `RESET_JTAG` parameter (default 1, so JTAG mode), and `switch_pulse_o` and `tap_reset_o` are 0.
- R2: The select word is only accepted after at least `LRST_LEN` (default 50) consecutive ones. A 0 sampled before that many ones restarts the count, so a correct word that follows a run of 49 ones changes nothing.
- R3: The select word is `SEL_WORD` (default 16'hE73C), taken least-significant bit first, and its bit 0 must follow the run directly. On the edge that samples bit 15, `jtag_mode_o` goes to 1 and `switch_pulse_o` is 1 for exactly that one cycle.
- R4: If any sampled bit differs from the expected word bit, detection is abandoned and `jtag_mode_o` keeps its value. A new full run of ones is then needed before another attempt.
- R5: While `jtag_mode_o` is 1, `tap_reset_o` is 1 from the edge that samples the `TRAIL_LEN`-th (default 5) consecutive 1 onward, until the next 0. Ones are counted from the last 0 or from the end of an accepted select word, whichever is later.
- R6: While `jtag_mode_o` is 0, `tap_reset_o` stays 0 whatever the line does.
- R7: A select word accepted while already in JTAG mode still gives the one-cycle pulse, and the mode stays 1.
- R8: The ones count saturates, so a run far longer than `LRST_LEN` (for example 206 ones) still arms acceptance of the select word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Debug clock; the line is sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 1 | Shared serial-wire data / TMS line |
| jtag_mode_o | output | 1 | 1 when the port is in JTAG mode, 0 in serial-wire mode |
| switch_pulse_o | output | 1 | One-cycle pulse when a select word is accepted |
| tap_reset_o | output | 1 | Enough ones seen in JTAG mode to force Test-Logic-Reset |

## Verification
Every result belongs to the rising edge that samples the bit causing it. The mode and the pulse are registers, so they change on that edge. `tap_reset_o` is decoded from registered state and changes on the same edge, with no extra cycle. The bench drives each bit at the falling edge and, for each bit, pushes the outputs the requirements predict after that bit's rising edge. A monitor pops and compares them 2 ns after every rising edge, so each comparison lands after the due edge and before the next bit is driven.

// File: rtl/swj_pkg.sv
package swj_pkg;

    typedef enum logic {
        MS_HUNT = 1'b0,
        MS_CMP  = 1'b1
    } match_state_e;

    typedef struct packed {
        logic mode;
        logic pulse;
    } port_regs_t;

endpackage

// File: rtl/swj_run_count.sv
module swj_run_count #(
    parameter int MAX   = 50,
    parameter int CNT_W = $clog2(MAX + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             bit_i,
    input  logic             clear_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             sat_o
);

    localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (!bit_i) begin
            cnt_d = '0;
        end else if (cnt_q != MAX_C) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o = cnt_q;
    assign sat_o = (cnt_q == MAX_C);

    assert_run_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= MAX_C);

    assert_zero_restarts_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !bit_i |=> (cnt_q == '0));

    assert_sat_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sat_o && bit_i && !clear_i) |=> sat_o);

endmodule

// File: rtl/swj_seq_match.sv
module swj_seq_match
    import swj_pkg::*;
#(
    parameter int               PAT_W    = 16,
    parameter logic [PAT_W-1:0] SEL_WORD = 16'hE73C
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic bit_i,
    input  logic armed_i,
    output logic busy_o,
    output logic hit_o
);

    localparam int             IDX_W = $clog2(PAT_W);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(PAT_W - 1);

    typedef struct packed {
        match_state_e     st;
        logic [IDX_W-1:0] idx;
    } mregs_t;

    mregs_t r_d, r_q;

    always_comb begin
        r_d   = r_q;
        hit_o = 1'b0;
        unique case (r_q.st)
            MS_HUNT: begin
                if (armed_i && (bit_i == SEL_WORD[0])) begin
                    r_d.st  = MS_CMP;
                    r_d.idx = IDX_W'(1);
                end
            end
            MS_CMP: begin
                if (bit_i == SEL_WORD[r_q.idx]) begin
                    if (r_q.idx == LAST) begin
                        hit_o   = 1'b1;
                        r_d.st  = MS_HUNT;
                        r_d.idx = '0;
                    end else begin
                        r_d.idx = r_q.idx + 1'b1;
                    end
                end else begin
                    r_d.st  = MS_HUNT;
                    r_d.idx = '0;
                end
            end
            default: r_d = r_q;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '{st: MS_HUNT, idx: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o = (r_q.st == MS_CMP);

    assert_start_needs_run_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> $past(armed_i));

    assert_index_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |-> ((r_q.idx != '0) && (r_q.idx <= LAST)));

    assert_miss_aborts_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && (bit_i != SEL_WORD[r_q.idx])) |=> !busy_o);

endmodule

// File: rtl/swj_mode_detect.sv
module swj_mode_detect
    import swj_pkg::*;
#(
    parameter int          LRST_LEN   = 50,
    parameter int          TRAIL_LEN  = 5,
    parameter int          PAT_W      = 16,
    parameter logic [15:0] SEL_WORD   = 16'hE73C,
    parameter logic        RESET_JTAG = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic line_i,
    output logic jtag_mode_o,
    output logic switch_pulse_o,
    output logic tap_reset_o
);

    localparam int               CNT_W   = $clog2(LRST_LEN + 1);
    localparam logic [CNT_W-1:0] TRAIL_C = CNT_W'(TRAIL_LEN);

    logic [CNT_W-1:0] run_cnt;
    logic             run_sat;
    logic             word_hit;
    logic             cmp_busy;

    swj_run_count #(
        .MAX   (LRST_LEN),
        .CNT_W (CNT_W)
    ) u_run (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .bit_i   (line_i),
        .clear_i (word_hit),
        .cnt_o   (run_cnt),
        .sat_o   (run_sat)
    );

    swj_seq_match #(
        .PAT_W    (PAT_W),
        .SEL_WORD (SEL_WORD[PAT_W-1:0])
    ) u_match (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .bit_i   (line_i),
        .armed_i (run_sat),
        .busy_o  (cmp_busy),
        .hit_o   (word_hit)
    );

    port_regs_t p_d, p_q;

    always_comb begin
        p_d       = p_q;
        p_d.pulse = word_hit;
        if (word_hit) begin
            p_d.mode = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            p_q <= '{mode: RESET_JTAG, pulse: 1'b0};
        end else begin
            p_q <= p_d;
        end
    end

    assign jtag_mode_o    = p_q.mode;
    assign switch_pulse_o = p_q.pulse;
    assign tap_reset_o    = p_q.mode && (run_cnt >= TRAIL_C);

    assert_pulse_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        switch_pulse_o |=> !switch_pulse_o);

    assert_pulse_in_jtag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        switch_pulse_o |-> jtag_mode_o);

    assert_mode_kept_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$fell(jtag_mode_o));

    assert_mode_rise_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(jtag_mode_o) |-> switch_pulse_o);

    assert_pulse_restarts_trail_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        switch_pulse_o |-> !tap_reset_o);

    assert_pulse_not_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        switch_pulse_o |-> !cmp_busy);

endmodule

// File: tb/swj_mode_detect_bench.sv
`timescale 1ns/1ps
module swj_mode_detect_bench;

    localparam logic [15:0] WORD = 16'hE73C;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    logic line  = 1'b0;

    logic mode_a, pulse_a, tap_a;
    logic mode_b, pulse_b, tap_b;

    always #4 clk = ~clk;

    swj_mode_detect u_swj_mode_detect (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .line_i         (line),
        .jtag_mode_o    (mode_a),
        .switch_pulse_o (pulse_a),
        .tap_reset_o    (tap_a)
    );

    swj_mode_detect #(.RESET_JTAG(1'b0)) u_swj_mode_detect_swd (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .line_i         (line),
        .jtag_mode_o    (mode_b),
        .switch_pulse_o (pulse_b),
        .tap_reset_o    (tap_b)
    );

    int checks = 0;
    int fails  = 0;

    logic [65:0] hist  = '0;
    int          nsent = 0;
    int          trail = 0;
    logic        m_a   = 1'b1;
    logic        m_b   = 1'b0;

    logic [5:0] exp_q[$];
    string      tag_q[$];

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    // Expected outputs after each bit follow R3, R5, R6, R7: the word counts only
    // when the 50 bits before it are all ones (R2, R8).
    task automatic drive_bit(input logic b, input string tag);
        logic hit;
        @(negedge clk);
        line  = b;
        hist  = {hist[64:0], b};
        nsent = nsent + 1;
        hit   = (nsent >= 66);
        for (int i = 0; i < 50; i++) if (!hist[16+i]) hit = 1'b0;
        for (int i = 0; i < 16; i++) if (hist[15-i] != WORD[i]) hit = 1'b0;
        if (hit) begin
            m_a   = 1'b1;
            m_b   = 1'b1;
            trail = 0;
        end else begin
            trail = b ? trail + 1 : 0;
        end
        exp_q.push_back({m_a, hit, m_a && (trail >= 5), m_b, hit, m_b && (trail >= 5)});
        tag_q.push_back(tag);
    endtask

    task automatic send_ones(input int n, input string tag);
        for (int i = 0; i < n; i++) drive_bit(1'b1, tag);
    endtask

    task automatic send_word(input logic [15:0] w, input string tag);
        for (int i = 0; i < 16; i++) drive_bit(w[i], tag);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() != 0) begin
                logic [5:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, "jtag_mode_a", mode_a, e[5]);
                check(t, "pulse_a",     pulse_a, e[4]);
                check(t, "tap_reset_a", tap_a,  e[3]);
                check(t, "jtag_mode_b", mode_b, e[2]);
                check(t, "pulse_b",     pulse_b, e[1]);
                check(t, "tap_reset_b", tap_b,  e[0]);
            end
        end
    end

    initial begin
        #800000;
        fails++;
        $display("FAIL R3 watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R1", "mode_a in reset",  mode_a,  1'b1);
        check("R1", "mode_b in reset",  mode_b,  1'b0);
        check("R1", "pulse_a in reset", pulse_a, 1'b0);
        check("R1", "tap_a in reset",   tap_a,   1'b0);
        rst_n = 1'b1;
        #1;
        check("R1", "mode_a after reset",  mode_a,  1'b1);
        check("R1", "mode_b after reset",  mode_b,  1'b0);
        check("R1", "pulse_b after reset", pulse_b, 1'b0);
        check("R1", "tap_b after reset",   tap_b,   1'b0);

        send_ones(7, "R5 R6 ones from reset");
        drive_bit(1'b0, "R2 run broken");
        send_ones(49, "R2 run of 49");
        send_word(WORD, "R2 word after short run");
        send_ones(60, "R4 long run");
        send_word(WORD ^ 16'h0080, "R4 corrupted word");
        send_ones(3, "R4 after abort");
        drive_bit(1'b0, "R3 gap");
        send_ones(50, "R3 exact run");
        send_word(WORD, "R3 word accepted");
        send_ones(6, "R5 trailing ones");
        send_ones(200, "R8 saturating run");
        send_word(WORD, "R7 R8 word in jtag");
        send_ones(5, "R7 R5 trailing");
        drive_bit(1'b0, "R5 zero clears");

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule